// File: doc/BRIEF.md
# Accumulator Cut with Rounding and Saturation

This block takes a signed 64-bit accumulator and a cut-point operand, and returns a signed 32-bit slice of the accumulator. The cut point picks where the slice sits. The accumulator is treated as if it were sign-extended far beyond its own width. This lets the slice reach well above the top of the word, which gives a left shift that can overflow. It can also reach well below the bottom of the word, which gives a right shift that leaves only sign bits.

When the slice drops low-order bits, the result is rounded to nearest, with ties going up. When significant high-order bits would be lost, the result is clamped to the signed 32-bit limits and a flag is raised.

A producer presents the accumulator and the cut operand together with a valid strobe. The rounded and clamped result, its valid bit and the saturation flag come out of a register one clock later. Back-to-back operations are accepted on every cycle.

Top module: `acc_cut_unit`

## Requirements
- R1: Only bits [6:0] of `in_cut` are used, read as a two's-complement cut value c in the range -64..+63. Higher operand bits have no effect on the result, so 64 acts as -64, 128 acts as 0, and 0x123456FF acts as -1.
- R2: With the accumulator sign-extended to 128 bits, bit 31 of the unclamped result is bit (63 - c) of that value. Bit 0 of the result is bit (32 - c).
- R3: When c < 32, the bits below result bit 0 are discarded. If the highest discarded bit, bit (31 - c) of the extended value, is 1, the kept value is increased by one. When c >= 32, no bits are discarded and no rounding applies.
- R4: The rounding increment is skipped when the kept value is already 0x7FFFFFFF or more, so rounding by itself never produces an overflow. For example, accumulator 0x00000000_FFFFFFFF with c = 31 yields 0x7FFFFFFF with the flag clear.
- R5: A negative cut is an arithmetic right shift by |c| followed by a cut of 0. A cut of -64 leaves only sign bits. Small negative values whose rounding bit is 1 (for example -1 with c = -32) therefore round to 0, not to -1.
- R6: If the rounded value is above 0x7FFFFFFF, the output is 0x7FFFFFFF. If it is below -0x80000000, the output is 0x80000000. In both cases `out_sat` is 1 in the same cycle as that result. Otherwise `out_sat` is 0 and the output is the low 32 bits of the value.
- R7: `out_valid` is 1 exactly on the clock after a cycle with `in_valid` = 1, and 0 otherwise. `out_sat` is 0 whenever `out_valid` is 0.
- R8: A synchronous active-high `rst` clears `out_valid`, `out_sat` and `out_data` on the next clock edge. An operation presented while `rst` is 1 produces no result.
- R9: `out_data` keeps the last result for as long as no new operation is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe for `in_acc` and `in_cut` |
| in_acc | input | 64 | Signed accumulator value |
| in_cut | input | 32 | Cut operand; only bits [6:0] are used |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_data | output | 32 | Rounded and clamped signed result |
| out_sat | output | 1 | Result was clamped to a signed limit |

## Verification
The datapath is purely combinational between the input strobe and a single register stage. Any wrong decode of the cut field, a pre-shift of the wrong length, a rounding bit taken from the wrong position or a misplaced guard therefore shows up as a wrong `out_data` or `out_sat` on the very next result, and on no later one. Results are compared against a model that works directly on a 128-bit sign extension. The comparison sweeps every cut value over one accumulator and probes the corners where the model and a faulty datapath part ways: ties at the 0x7FFFFFFF ceiling, the full shift-out at -64, and both saturation limits. Timing faults, such as a lost strobe, a stale flag, or a result that is not held, are visible on the first idle or reset cycle after an operation.

// File: rtl/acc_cut_pkg.sv
package acc_cut_pkg;

    localparam int ACC_W = 64;
    localparam int RES_W = 32;
    localparam int CUT_W = $clog2(ACC_W) + 1;
    localparam int POS_W = CUT_W - 1;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic        [RES_W-1:0] res_t;

    // Cut after the negative-shift step: a shifted source and a non-negative position.
    typedef struct packed {
        acc_t             aligned;
        logic [POS_W-1:0] pos;
    } cut_plan_t;

    // Unclamped window: low result bits plus the guard value (value >>> (RES_W-1)).
    typedef struct packed {
        res_t lower;
        acc_t guard;
    } window_t;

    typedef struct packed {
        res_t data;
        logic sat;
    } cut_out_t;

    localparam res_t RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam res_t RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

    // Largest kept value that may still take the rounding increment plus one.
    localparam acc_t ROUND_CAP = acc_t'({{(ACC_W-RES_W){1'b0}}, RES_MAX});

endpackage

// File: rtl/acc_cut_align.sv
module acc_cut_align
    import acc_cut_pkg::*;
(
    input  acc_t             acc_i,
    input  logic [CUT_W-1:0] cut_i,
    output cut_plan_t        plan_o
);

    logic [CUT_W-1:0] mag;
    logic [CUT_W-1:0] rsh;

    always_comb begin
        mag = -cut_i;
        // A magnitude equal to the word width shifts one place less: only sign bits remain.
        rsh = (mag == CUT_W'(ACC_W)) ? CUT_W'(ACC_W - 1) : mag;
        if (cut_i[CUT_W-1]) begin
            plan_o.aligned = acc_i >>> rsh;
            plan_o.pos     = '0;
        end else begin
            plan_o.aligned = acc_i;
            plan_o.pos     = cut_i[POS_W-1:0];
        end
    end

endmodule

// File: rtl/acc_cut_window.sv
module acc_cut_window
    import acc_cut_pkg::*;
(
    input  cut_plan_t plan_i,
    output window_t   win_o
);

    localparam logic [CUT_W-1:0] RES_C = CUT_W'(RES_W);
    localparam logic [CUT_W-1:0] TOP_C = CUT_W'(ACC_W - 1);

    acc_t             src;
    acc_t             trunc;
    acc_t             value;
    acc_t             guard;
    logic [CUT_W-1:0] pos_w;
    logic [CUT_W-1:0] rsh;
    logic [CUT_W-1:0] lsh;
    logic [CUT_W-1:0] gsh;
    logic             rbit;

    always_comb begin
        src   = plan_i.aligned;
        pos_w = {1'b0, plan_i.pos};
        rsh   = RES_C - pos_w;
        lsh   = pos_w - RES_C;
        gsh   = TOP_C - pos_w;
        trunc = src >>> rsh;
        rbit  = |(src & (acc_t'(1) << (rsh - 1'b1)));
        if (pos_w < RES_C) begin
            value = trunc;
            if (rbit && (trunc < ROUND_CAP)) begin
                value = trunc + acc_t'(1);
            end
            guard = value >>> (RES_W - 1);
        end else begin
            value = src << lsh;
            guard = src >>> gsh;
        end
        win_o.lower = value[RES_W-1:0];
        win_o.guard = guard;
    end

endmodule

// File: rtl/acc_cut_clamp.sv
module acc_cut_clamp
    import acc_cut_pkg::*;
(
    input  window_t  win_i,
    output cut_out_t out_o
);

    localparam acc_t NEG_ONE = '1;
    localparam acc_t ZERO    = '0;

    acc_t g;

    always_comb begin
        g = win_i.guard;
        if (g < NEG_ONE) begin
            out_o.data = RES_MIN;
            out_o.sat  = 1'b1;
        end else if (g > ZERO) begin
            out_o.data = RES_MAX;
            out_o.sat  = 1'b1;
        end else begin
            out_o.data = win_i.lower;
            out_o.sat  = 1'b0;
        end
    end

endmodule

// File: rtl/acc_cut_unit.sv
module acc_cut_unit
    import acc_cut_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [ACC_W-1:0] in_acc,
    input  logic [OP_W-1:0]  in_cut,
    output logic             out_valid,
    output logic [RES_W-1:0] out_data,
    output logic             out_sat
);

    acc_t      acc_s;
    cut_plan_t plan;
    window_t   win;
    cut_out_t  res;
    logic      cut_hi_unused;

    assign acc_s = in_acc;

    generate
        if (OP_W > CUT_W) begin : g_wide_op
            assign cut_hi_unused = ^in_cut[OP_W-1:CUT_W];
        end else begin : g_narrow_op
            assign cut_hi_unused = 1'b0;
        end
    endgenerate

    acc_cut_align u_align (
        .acc_i  (acc_s),
        .cut_i  (in_cut[CUT_W-1:0]),
        .plan_o (plan)
    );

    acc_cut_window u_window (
        .plan_i (plan),
        .win_o  (win)
    );

    acc_cut_clamp u_clamp (
        .win_i (win),
        .out_o (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sat   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= res.data;
                out_sat  <= res.sat;
            end else begin
                out_sat  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/acc_cut_chk.sv
module acc_cut_chk
    import acc_cut_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             acc_sign,
    input logic             out_valid,
    input logic [RES_W-1:0] out_data,
    input logic             out_sat
);

    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_flag_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_sat);

    p_sat_limit_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sat) |-> (out_data == RES_MAX || out_data == RES_MIN));

    p_sat_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sat) |-> (out_data[RES_W-1] == $past(acc_sign)));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sat && out_data == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

endmodule

bind acc_cut_unit acc_cut_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .acc_sign  (in_acc[63]),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sat   (out_sat)
);

// File: tb/acc_cut_unit_tb.sv
`timescale 1ns/1ps
module acc_cut_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_acc = '0;
    logic [31:0] in_cut = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_sat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        sat;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] last_data;
    bit          have_last = 1'b0;

    always #2 clk = ~clk;

    acc_cut_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_acc    (in_acc),
        .in_cut    (in_cut),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sat   (out_sat)
    );

    // Expected result from the 128-bit sign-extension view: {sat, data}.
    function automatic logic [32:0] model(input logic [63:0] a, input logic [31:0] op);
        logic signed [6:0]   c;
        logic signed [127:0] ext;
        logic signed [127:0] v;
        int                  sh;
        c   = op[6:0];
        ext = {{64{a[63]}}, a};
        sh  = 32 - int'(c);
        if (sh > 0) begin
            v = ext >>> sh;
            if (ext[sh-1] && (v < 128'sh7FFFFFFF)) v = v + 128'sd1;
        end else begin
            v = ext <<< (-sh);
        end
        if (v > 128'sh7FFFFFFF)        return {1'b1, 32'h7FFFFFFF};
        if (v < -(128'sh80000000))     return {1'b1, 32'h80000000};
        return {1'b0, v[31:0]};
    endfunction

    task automatic push_drive(input logic [63:0] a, input logic [31:0] c,
                              input logic [31:0] ed, input logic es, input string tag);
        exp_t e;
        in_valid = 1'b1;
        in_acc   = a;
        in_cut   = c;
        e.data   = ed;
        e.sat    = es;
        e.tag    = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic drive_m(input logic [63:0] a, input logic [31:0] c, input string tag);
        logic [32:0] m;
        m = model(a, c);
        push_drive(a, c, m[31:0], m[32], tag);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: scoreboard compare, hold and flag checks.
    always @(posedge clk) begin
        #1;
        if (rst) begin
            have_last = 1'b0;
        end else if (out_valid) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R7 unexpected result: actual out_valid=1 expected out_valid=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (out_data !== e.data || out_sat !== e.sat) begin
                    fails++;
                    $display("FAIL %s result: actual data=%h sat=%b expected data=%h sat=%b",
                             e.tag, out_data, out_sat, e.data, e.sat);
                end
            end
            last_data = out_data;
            have_last = 1'b1;
        end else begin
            checks++;
            if (out_sat !== 1'b0) begin
                fails++;
                $display("FAIL R7 idle flag: actual sat=%b expected sat=0", out_sat);
            end
            if (have_last) begin
                checks++;
                if (out_data !== last_data) begin
                    fails++;
                    $display("FAIL R9 hold: actual data=%h expected data=%h", out_data, last_data);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog: actual done=0 expected done=1");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        checks++;
        if (out_valid !== 1'b0 || out_sat !== 1'b0 || out_data !== 32'h0) begin
            fails++;
            $display("FAIL R8 reset state: actual v=%b s=%b d=%h expected v=0 s=0 d=00000000",
                     out_valid, out_sat, out_data);
        end

        // R2/R3/R5/R6: stated vectors, expected values written out
        push_drive(64'hFFFFFEDC_BA987654, 32'd16,          32'hFEDCBA98, 1'b0, "R2");
        push_drive(64'hFFFFFEDC_BA987654, 32'd12,          32'hFFEDCBAA, 1'b0, "R3");
        push_drive(64'hFFFFFEDC_BA987654, -32'sd4,         32'hFFFFFFEE, 1'b0, "R5");
        push_drive(64'hFFFFFEDC_BA987654, 32'd24,          32'h80000000, 1'b1, "R6");
        push_drive(64'h6789ABCD_EFA5A5A5, -32'sd1,         32'h33C4D5E7, 1'b0, "R3");
        push_drive(64'h6789ABCD_EFA5A5A5, -32'sd31,        32'h00000001, 1'b0, "R5");
        idle(2);

        // R1: upper operand bits ignored
        push_drive(64'h6789ABCD_EFA5A5A5, 32'h123456FF,    32'h33C4D5E7, 1'b0, "R1");
        push_drive(64'hFFFFFEDC_BA987654, 32'd128,         32'hFFFFFEDD, 1'b0, "R1");
        push_drive(64'hFFFFFFFF_FFFFFFFF, 32'd64,          32'h00000000, 1'b0, "R1");
        push_drive(64'hFFFFFEDC_BA987654, 32'hFFFFFF90,    32'hFEDCBA98, 1'b0, "R1");

        // R4: rounding ceiling
        push_drive(64'h00000000_FFFFFFFF, 32'd31,          32'h7FFFFFFF, 1'b0, "R4");
        push_drive(64'h00000000_FFFFFFFD, 32'd31,          32'h7FFFFFFF, 1'b0, "R4");
        push_drive(64'h00000000_FFFFFFFE, 32'd31,          32'h7FFFFFFF, 1'b0, "R4");
        push_drive(64'h00000000_7FFFFFFF, 32'd32,          32'h7FFFFFFF, 1'b0, "R3");

        // R5: full shift-out and small negatives rounding to zero
        push_drive(64'hFFFFFFFF_FFFFFFFF, -32'sd32,        32'h00000000, 1'b0, "R5");
        push_drive(64'hFFFFFFFF_FFFFFFFF, -32'sd30,        32'h00000000, 1'b0, "R5");
        push_drive(64'h80000000_00000000, -32'sd64,        32'h00000000, 1'b0, "R5");
        push_drive(64'h7FFFFFFF_FFFFFFFF, -32'sd64,        32'h00000000, 1'b0, "R5");
        push_drive(64'h80000000_00000000, -32'sd63,        32'h00000000, 1'b0, "R5");

        // R6: both limits and no-round left shift
        push_drive(64'h80000000_00000000, 32'd63,          32'h80000000, 1'b1, "R6");
        push_drive(64'h00000000_00000001, 32'd63,          32'h7FFFFFFF, 1'b1, "R6");
        push_drive(64'h00000000_00012345, 32'd40,          32'h01234500, 1'b0, "R3");
        push_drive(64'hFFFFFFFF_80000000, 32'd32,          32'h80000000, 1'b0, "R6");
        idle(3);

        // R8: operation presented during reset produces nothing
        rst = 1'b1; in_valid = 1'b1; in_acc = 64'h1; in_cut = 32'd63;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b0 || out_sat !== 1'b0 || out_data !== 32'h0) begin
            fails++;
            $display("FAIL R8 mid reset: actual v=%b s=%b d=%h expected v=0 s=0 d=00000000",
                     out_valid, out_sat, out_data);
        end
        idle(2);

        // R2: sweep every cut over one accumulator
        for (int c = -64; c < 64; c++) begin
            drive_m(64'h6789ABCD_EFA5A5A5, 32'(c), "R2");
        end
        idle(2);

        // R2/R6: random accumulators of mixed magnitude, random operands
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a;
            a = {$urandom, $urandom};
            a = 64'($signed(a) >>> ($urandom % 64));
            drive_m(a, $urandom, "R2");
            if (i % 17 == 0) idle(1);
        end
        idle(4);

        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R7 missing results: actual pending=%0d expected pending=0", q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule